// File: doc/BRIEF.md
# Polled EEPROM Byte Writer

This block sits on the host side of a byte-wide parallel EEPROM and turns one write request into a full bus transaction. A request (address and byte) is taken on a valid/ready handshake. The block then drives chip select, write enable and the data bus through a setup, pulse and hold sequence. Each of these intervals is a whole number of clock cycles set by a parameter.

After the write, the block does not wait for the worst-case programming time. It repeatedly reads back the address it just wrote, with a programmable idle gap between reads. While the device is still programming, it returns the top data bit inverted. Once the top bit of the read-back matches the stored byte, the block reports completion.

A timeout, expressed in clock cycles and turned into a number of read-backs, bounds the loop. When that bound is reached the block reports an error instead of completion. A `busy` output covers the whole operation. The read-back path can optionally pass through a chain of input flops, selected by a parameter.

Top module: `eep_poll_writer`

## Requirements
- R1: After reset `req_ready`=1, `busy`=0, `done`=0, `err`=0, `mem_cs_n`=`mem_we_n`=`mem_oe_n`=1 and `mem_dout_en`=0.
- R2: A request is accepted on a rising clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle until the cycle carrying `done` or `err`. A request presented while `req_ready` is 0 is not taken and does not alter the address or byte being driven.
- R3: For the SETUP_CYC cycles after acceptance, `mem_cs_n`=0, `mem_we_n`=1 and `mem_oe_n`=1. The accepted address is on `mem_addr` and the accepted byte is on `mem_dout` with `mem_dout_en`=1.
- R4: For the next PULSE_CYC cycles, `mem_we_n`=0 with `mem_cs_n`=0, `mem_oe_n`=1 and the data still driven. `mem_oe_n` stays 1 whenever `mem_we_n` is 0.
- R5: For HOLD_CYC cycles after `mem_we_n` returns to 1, `mem_cs_n`=0 and the byte stays driven on `mem_dout`.
- R6: Before each read-back there are GAP_CYC cycles with `mem_cs_n`, `mem_we_n` and `mem_oe_n` all 1 and `mem_dout_en`=0.
- R7: Each read-back lasts READ_CYC cycles with `mem_cs_n`=0, `mem_oe_n`=0, `mem_we_n`=1, `mem_dout_en`=0, and the stored address on `mem_addr`.
- R8: At the end of a read-back, the block compares bit DATA_W-1 of `mem_din` with the same bit of the stored byte. With IN_STAGES input flops, the value used is the one sampled IN_STAGES cycles before the last read cycle ends. If the bits are equal, `done` is 1 for exactly the following cycle, in which `busy`=0 and `req_ready`=1.
- R9: If the compared bits differ and the poll limit is not reached, another gap and read-back follow.
- R10: The poll limit is ceil(TIMEOUT_CYC / (GAP_CYC + READ_CYC)) read-backs. If the read-back with that number still differs, `err` is 1 for exactly the following cycle, `done` stays 0 and the block is idle again.
- R11: `busy` is 1 from the cycle after acceptance through the last read-back cycle, and it falls only in a cycle where `done` or `err` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | ADDR_W | Byte address to write |
| req_data | input | DATA_W | Byte to write |
| busy | output | 1 | Write or polling in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle timeout pulse |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dout | output | DATA_W | Byte driven toward memory |
| mem_dout_en | output | 1 | Enable for the memory data driver |
| mem_din | input | DATA_W | Byte read back from memory |

## Verification
The bench builds the block with setup 2, pulse 3, hold 1, gap 4, read 2, timeout 60 cycles and one input flop. These values put every phase boundary within a few cycles and give a limit of 10 read-backs, so a single-poll match, a several-poll match and a full timeout can all be reached in short runs. Using one input flop exercises the delayed-sample variant of the comparison. The bench's memory model keeps the top bit inverted for a chosen number of cycles after each write, and it flags any write enable that is asserted while output enable is low.

// File: rtl/eep_poll_pkg.sv
package eep_poll_pkg;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_SETUP = 3'd1,
      PH_PULSE = 3'd2,
      PH_HOLD  = 3'd3,
      PH_GAP   = 3'd4,
      PH_READ  = 3'd5
   } eep_phase_t;

   function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
      return (num + den - 1) / den;
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/eep_phase_timer.sv
module eep_phase_timer #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          expired
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);
endmodule

// File: rtl/eep_din_sync.sv
module eep_din_sync #(
   parameter int W      = 8,
   parameter int STAGES = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   generate
      if (STAGES == 0) begin : g_direct
         assign dout = din;
      end else begin : g_flops
         logic [W-1:0] pipe_q [STAGES];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) pipe_q[i] <= '0;
            end else begin
               pipe_q[0] <= din;
               for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
            end
         end
         assign dout = pipe_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/eep_poll_tracker.sv
module eep_poll_tracker #(
   parameter int ADDR_W     = 15,
   parameter int DATA_W     = 8,
   parameter int POLL_LIMIT = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [ADDR_W-1:0] cap_addr,
   input  logic [DATA_W-1:0] cap_data,
   input  logic              poll_adv,
   input  logic [DATA_W-1:0] rd_byte,
   output logic [ADDR_W-1:0] held_addr,
   output logic [DATA_W-1:0] held_data,
   output logic              flag_match,
   output logic              last_poll
);
   localparam int FLAG_BIT = DATA_W - 1;
   localparam int PW       = $clog2(POLL_LIMIT + 1);
   localparam logic [PW-1:0] LAST_IDX = PW'(POLL_LIMIT - 1);

   logic [PW-1:0] poll_idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_addr  <= '0;
         held_data  <= '0;
         poll_idx_q <= '0;
      end else if (capture) begin
         held_addr  <= cap_addr;
         held_data  <= cap_data;
         poll_idx_q <= '0;
      end else if (poll_adv) begin
         poll_idx_q <= poll_idx_q + 1'b1;
      end
   end

   assign flag_match = (rd_byte[FLAG_BIT] == held_data[FLAG_BIT]);
   assign last_poll  = (poll_idx_q == LAST_IDX);
endmodule

// File: rtl/eep_poll_writer.sv
module eep_poll_writer
   import eep_poll_pkg::*;
#(
   parameter int ADDR_W      = 15,
   parameter int DATA_W      = 8,
   parameter int SETUP_CYC   = 2,
   parameter int PULSE_CYC   = 8,
   parameter int HOLD_CYC    = 1,
   parameter int GAP_CYC     = 50,
   parameter int READ_CYC    = 10,
   parameter int TIMEOUT_CYC = 500000,
   parameter int IN_STAGES   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_data,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic              mem_cs_n,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dout,
   output logic              mem_dout_en,
   input  logic [DATA_W-1:0] mem_din
);
   localparam int POLL_CYC   = GAP_CYC + READ_CYC;
   localparam int POLL_LIMIT = ceil_div(TIMEOUT_CYC, POLL_CYC);
   localparam int MAX_PH     = max2(max2(SETUP_CYC, PULSE_CYC),
                                    max2(max2(HOLD_CYC, GAP_CYC), READ_CYC));
   localparam int CW         = $clog2(MAX_PH + 1);
   localparam logic [CW-1:0] LD_SETUP = CW'(SETUP_CYC - 1);
   localparam logic [CW-1:0] LD_PULSE = CW'(PULSE_CYC - 1);
   localparam logic [CW-1:0] LD_HOLD  = CW'(HOLD_CYC - 1);
   localparam logic [CW-1:0] LD_GAP   = CW'(GAP_CYC - 1);
   localparam logic [CW-1:0] LD_READ  = CW'(READ_CYC - 1);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("DATA_W must be at least 2");
      end
      if (SETUP_CYC < 1 || PULSE_CYC < 1 || HOLD_CYC < 1 || GAP_CYC < 1) begin : g_bad_phase
         $error("every write and gap phase needs at least one cycle");
      end
      if (READ_CYC <= IN_STAGES) begin : g_bad_read
         $error("READ_CYC must exceed IN_STAGES");
      end
      if (TIMEOUT_CYC < 1) begin : g_bad_timeout
         $error("TIMEOUT_CYC must be positive");
      end
   endgenerate

   eep_phase_t    phase_q;
   eep_phase_t    phase_d;
   logic          tmr_load;
   logic [CW-1:0] tmr_val;
   logic          tmr_exp;
   logic          accept;
   logic          poll_adv;
   logic          flag_match;
   logic          last_poll;
   logic          done_d;
   logic          err_d;
   logic [DATA_W-1:0] rd_sync;
   logic [ADDR_W-1:0] held_addr;
   logic [DATA_W-1:0] held_data;

   assign accept = req_valid && (phase_q == PH_IDLE);

   always_comb begin
      phase_d  = phase_q;
      tmr_load = 1'b0;
      tmr_val  = LD_SETUP;
      poll_adv = 1'b0;
      done_d   = 1'b0;
      err_d    = 1'b0;
      unique case (phase_q)
         PH_IDLE: begin
            if (accept) begin
               phase_d  = PH_SETUP;
               tmr_load = 1'b1;
               tmr_val  = LD_SETUP;
            end
         end
         PH_SETUP: begin
            if (tmr_exp) begin
               phase_d  = PH_PULSE;
               tmr_load = 1'b1;
               tmr_val  = LD_PULSE;
            end
         end
         PH_PULSE: begin
            if (tmr_exp) begin
               phase_d  = PH_HOLD;
               tmr_load = 1'b1;
               tmr_val  = LD_HOLD;
            end
         end
         PH_HOLD: begin
            if (tmr_exp) begin
               phase_d  = PH_GAP;
               tmr_load = 1'b1;
               tmr_val  = LD_GAP;
            end
         end
         PH_GAP: begin
            if (tmr_exp) begin
               phase_d  = PH_READ;
               tmr_load = 1'b1;
               tmr_val  = LD_READ;
            end
         end
         PH_READ: begin
            if (tmr_exp) begin
               if (flag_match) begin
                  phase_d = PH_IDLE;
                  done_d  = 1'b1;
               end else if (last_poll) begin
                  phase_d = PH_IDLE;
                  err_d   = 1'b1;
               end else begin
                  phase_d  = PH_GAP;
                  tmr_load = 1'b1;
                  tmr_val  = LD_GAP;
                  poll_adv = 1'b1;
               end
            end
         end
         default: phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         done    <= 1'b0;
         err     <= 1'b0;
      end else begin
         phase_q <= phase_d;
         done    <= done_d;
         err     <= err_d;
      end
   end

   eep_phase_timer #(.CW(CW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_exp)
   );

   eep_din_sync #(.W(DATA_W), .STAGES(IN_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (mem_din),
      .dout  (rd_sync)
   );

   eep_poll_tracker #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .POLL_LIMIT (POLL_LIMIT)
   ) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .capture    (accept),
      .cap_addr   (req_addr),
      .cap_data   (req_data),
      .poll_adv   (poll_adv),
      .rd_byte    (rd_sync),
      .held_addr  (held_addr),
      .held_data  (held_data),
      .flag_match (flag_match),
      .last_poll  (last_poll)
   );

   assign req_ready   = (phase_q == PH_IDLE);
   assign busy        = (phase_q != PH_IDLE);
   assign mem_cs_n    = !(phase_q inside {PH_SETUP, PH_PULSE, PH_HOLD, PH_READ});
   assign mem_we_n    = (phase_q != PH_PULSE);
   assign mem_oe_n    = (phase_q != PH_READ);
   assign mem_dout_en = (phase_q inside {PH_SETUP, PH_PULSE, PH_HOLD});
   assign mem_addr    = held_addr;
   assign mem_dout    = held_data;
endmodule

// File: rtl/eep_poll_writer_chk.sv
module eep_poll_writer_chk #(
   parameter int ADDR_W = 15
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              busy,
   input logic              done,
   input logic              err,
   input logic              mem_cs_n,
   input logic              mem_we_n,
   input logic              mem_oe_n,
   input logic              mem_dout_en,
   input logic [ADDR_W-1:0] mem_addr
);
   // R4
   we_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (mem_oe_n && !mem_cs_n));

   // R7
   read_undriven_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> !mem_dout_en);

   // R2
   ready_vs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !busy);

   // R10
   done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && err));

   // R3
   addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

   // R11
   busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (done || err));

   // R5
   we_rise_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (mem_dout_en && !mem_cs_n));
endmodule

bind eep_poll_writer eep_poll_writer_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_ready   (req_ready),
   .busy        (busy),
   .done        (done),
   .err         (err),
   .mem_cs_n    (mem_cs_n),
   .mem_we_n    (mem_we_n),
   .mem_oe_n    (mem_oe_n),
   .mem_dout_en (mem_dout_en),
   .mem_addr    (mem_addr)
);

// File: tb/tb_eep_poll_writer.sv
module tb_eep_poll_writer;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 15;
   localparam int DW = 8;
   localparam int S  = 2;
   localparam int W  = 3;
   localparam int H  = 1;
   localparam int G  = 4;
   localparam int R  = 2;
   localparam int TO = 60;
   localparam int ST = 1;
   localparam int LIMIT = (TO + G + R - 1) / (G + R);
   localparam int WR_END = S + W + H;

   logic clk = 0;
   logic rst_n = 0;
   logic req_valid = 0;
   logic req_ready;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_data = '0;
   logic busy, done, err;
   logic mem_cs_n, mem_we_n, mem_oe_n, mem_dout_en;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_dout;
   logic [DW-1:0] mem_din;

   int total = 0;
   int bad = 0;
   int cyc = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   eep_poll_writer #(
      .ADDR_W(AW), .DATA_W(DW), .SETUP_CYC(S), .PULSE_CYC(W), .HOLD_CYC(H),
      .GAP_CYC(G), .READ_CYC(R), .TIMEOUT_CYC(TO), .IN_STAGES(ST)
   ) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_data(req_data), .busy(busy), .done(done), .err(err),
      .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
      .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en),
      .mem_din(mem_din)
   );

   // ---------------- memory model ----------------
   bit [7:0] arr [256];
   int  prog_len = 0;
   int  busy_rem = 0;
   logic prev_we = 1'b1;
   logic [AW-1:0] last_a = '0;
   logic [7:0] rd_val;

   always @(negedge clk) begin
      if (!mem_cs_n && prev_we == 1'b0 && mem_we_n == 1'b1) begin
         arr[mem_addr[7:0]] = mem_dout;
         last_a   = mem_addr;
         busy_rem = prog_len;
      end else if (busy_rem > 0) begin
         busy_rem = busy_rem - 1;
      end
      prev_we = mem_we_n;
   end

   always_comb begin
      if (busy_rem > 0 && mem_addr == last_a)
         rd_val = {~arr[mem_addr[7:0]][7], arr[mem_addr[7:0]][6:0]};
      else
         rd_val = arr[mem_addr[7:0]];
   end
   assign mem_din = (!mem_cs_n && !mem_oe_n) ? rd_val : 8'h00;

   // ---------------- reference model ----------------
   bit act = 0;
   int t = 0;
   int n = 0;
   logic [AW-1:0] la = '0;
   logic [DW-1:0] ld = '0;
   logic [DW-1:0] din_d = '0;
   bit e_done = 0;
   bit e_err = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         act = 0; e_done = 0; e_err = 0; din_d = '0;
      end else begin
         e_done = 0; e_err = 0;
         if (!act) begin
            if (req_valid) begin
               act = 1; t = 1; n = 0; la = req_addr; ld = req_data;
            end
         end else if (t == WR_END + (n + 1) * (G + R)) begin
            if (din_d[DW-1] == ld[DW-1]) begin
               act = 0; e_done = 1;
            end else if (n == LIMIT - 1) begin
               act = 0; e_err = 1;
            end else begin
               n = n + 1; t = t + 1;
            end
         end else begin
            t = t + 1;
         end
         din_d = mem_din;
      end
   end

   task automatic chk(input string tag, input string what, input int act_v, input int exp_v);
      total++;
      if (act_v != exp_v) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", tag, what, act_v, exp_v, cyc);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         int e_cs, e_we, e_oe, e_den;
         string tg;
         e_cs = 1; e_we = 1; e_oe = 1; e_den = 0; tg = "R1";
         if (act) begin
            if (t <= S) begin
               e_cs = 0; e_den = 1; tg = "R3";
            end else if (t <= S + W) begin
               e_cs = 0; e_we = 0; e_den = 1; tg = "R4";
            end else if (t <= WR_END) begin
               e_cs = 0; e_den = 1; tg = "R5";
            end else if ((t - WR_END - 1) % (G + R) < G) begin
               tg = "R6";
            end else begin
               e_cs = 0; e_oe = 0; tg = "R7";
            end
         end
         chk("R2", "req_ready", req_ready, !act);
         chk("R11", "busy", busy, act);
         chk("R8", "done", done, e_done);
         chk("R10", "err", err, e_err);
         chk(tg, "mem_cs_n", mem_cs_n, e_cs);
         chk(tg, "mem_we_n", mem_we_n, e_we);
         chk(tg, "mem_oe_n", mem_oe_n, e_oe);
         chk(tg, "mem_dout_en", mem_dout_en, e_den);
         if (!mem_cs_n) chk(tg, "mem_addr", mem_addr, la);
         if (mem_dout_en) chk(tg, "mem_dout", mem_dout, ld);
      end
   end

   // count read-back phases per transaction
   int reads = 0;
   logic oe_prev = 1'b1;
   always @(negedge clk) begin
      if (oe_prev && !mem_oe_n) reads++;
      oe_prev = mem_oe_n;
   end

   // ---------------- watchdog ----------------
   always @(negedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input int prog,
                           input int junk_cycles, output bit got_done, output bit got_err);
      @(negedge clk);
      prog_len = prog;
      reads = 0;
      req_valid = 1; req_addr = a; req_data = d;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      // R2: keep a conflicting request on the bus while busy
      req_addr = ~a; req_data = ~d;
      for (int i = 0; i < junk_cycles; i++) @(negedge clk);
      req_valid = 0;
      while (!(done || err)) @(negedge clk);
      got_done = done; got_err = err;
   endtask

   initial begin
      bit gd, ge;
      repeat (3) @(negedge clk);
      // R1 reset state while held in reset
      chk("R1", "ready in reset", req_ready, 1);
      chk("R1", "busy in reset", busy, 0);
      chk("R1", "cs_n in reset", mem_cs_n, 1);
      chk("R1", "dout_en in reset", mem_dout_en, 0);
      rst_n = 1;

      // R8: matches on the first read-back, top bit 1
      do_write(15'h0012, 8'hA5, 0, 0, gd, ge);
      chk("R8", "done first poll", gd, 1);
      chk("R8", "single read-back", reads, 1);
      chk("R8", "stored byte", arr[8'h12], 8'hA5);

      // R9: several read-backs, top bit 0, junk request during busy (R2)
      do_write(15'h0134, 8'h3C, 20, 8, gd, ge);
      chk("R9", "done after polling", gd, 1);
      chk("R9", "more than one read-back", (reads > 1) ? 1 : 0, 1);
      chk("R2", "junk not written", arr[8'h34], 8'h3C);
      @(negedge clk);
      chk("R2", "junk not accepted", busy, 0);

      // R10: programming longer than the limit
      do_write(15'h0056, 8'h80, 500, 0, gd, ge);
      chk("R10", "err raised", ge, 1);
      chk("R10", "no done", gd, 0);
      chk("R10", "read-backs equal limit", reads, LIMIT);
      while (busy_rem > 0) @(negedge clk);

      // R8: back to normal after a timeout
      do_write(15'h7F01, 8'h7E, 3, 0, gd, ge);
      chk("R8", "done after timeout recovery", gd, 1);

      repeat (4) @(negedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule